// File: doc/BRIEF.md
# Comparator edge and fault controller

This block is the digital side of an analog comparator. It takes the comparator's asynchronous result bit, optionally inverts it, and passes it through a synchronizer chain. It then watches the synchronized level for a selected kind of transition. A matching transition sets a sticky edge flag, which can raise an interrupt line and can drive a fault output. The fault output can instead follow the live synchronized level.

Software reaches the block through a plain 32-bit register port with a one-cycle write strobe and a read strobe. Read data is combinational. The port holds the mode settings, an interrupt mask with separate set and clear locations, a status word, an analog trim register and a keyed lock. The input-select and trim fields are only stored and driven out to the analog macro. A keyed lock can freeze the mode and trim registers. Locked writes are dropped and recorded in a violation flag.

Top module: `cmp_edge_ctrl`

## Requirements
- R1: A write to the mode register at offset 0x04 stores the fields at these bits: minus select 2:0, plus select 6:4, enable 8, edge kind 10:9, invert 12, fault source 13, fault enable 14. Reads return them at the same bits, with every other bit 0. The select fields and the enable bit drive their output ports.
- R2: Bit 1 of the status register at offset 0x30 reports the synchronized comparator level. A change on the input shows there within three clock edges.
- R3: The edge flag, status bit 0, is set only while enable is 1. Edge kind 0 sets it on a rising level only, 1 on a falling level only and 2 on either. Edge kind 3 never sets it.
- R4: When invert is 1, the comparator input is inverted before synchronization, so both the status level and edge detection see the inverted value.
- R5: A status read returns the flag and clears it on that clock. If a qualifying edge is detected in the same cycle as the read, the flag stays set.
- R6: Writing 1 to bit 0 at offset 0x24 sets the interrupt mask, and writing 1 to bit 0 at offset 0x28 clears it. The mask reads back in bit 0 at offset 0x2C. The interrupt output is 1 exactly when both the flag and the mask are 1.
- R7: The fault output is 0 while fault enable is 0. Otherwise it follows the edge flag when fault source is 0, and the synchronized level when fault source is 1.
- R8: The analog register at offset 0x94 holds current select in bit 0 and hysteresis in bits 2:1. It reads back in place and drives its output ports.
- R9: A write at offset 0xE4 changes the lock bit, bit 0, only when bits 31:8 equal 0x414343. Reads at that offset return the lock in bit 0 and 0 in every key bit.
- R10: While the lock is set, writes to offsets 0x04 and 0x94 are ignored and set bit 0 at offset 0xE8. Reading offset 0xE8 clears that bit.
- R11: Reset, or a write of 1 to bit 0 at offset 0x00, returns every register and flag, the lock included, to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmp_i | input | 1 | Raw comparator result, asynchronous |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | ADDR_W | Byte offset of the access |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid in the strobe cycle |
| minus_sel_o | output | 3 | Minus input select |
| plus_sel_o | output | 3 | Plus input select |
| cmp_en_o | output | 1 | Comparator enable |
| cur_sel_o | output | 1 | Bias current select |
| hyst_o | output | 2 | Hysteresis select |
| fault_o | output | 1 | Fault output |
| irq_o | output | 1 | Interrupt request |

## Verification
A flag register that keeps the wrong state shows on `irq_o` or `fault_o` on the clock after it goes wrong, and shows in the next status read. An edge decoder on the wrong polarity is caught by the toggles run under each edge kind, with and without inversion, three edges after the input moves. A broken lock shows in the read of the mode register that follows a locked write, and in the violation bit. The race between a status read and a new edge is driven on the exact cycle the edge is detected, so a clear that wins over the set shows in the next status read.

// File: rtl/cmp_ctrl_pkg.sv
package cmp_ctrl_pkg;
  localparam logic [7:0] OFS_CTRL  = 8'h00;
  localparam logic [7:0] OFS_MODE  = 8'h04;
  localparam logic [7:0] OFS_IEN   = 8'h24;
  localparam logic [7:0] OFS_IDIS  = 8'h28;
  localparam logic [7:0] OFS_IMSK  = 8'h2C;
  localparam logic [7:0] OFS_STAT  = 8'h30;
  localparam logic [7:0] OFS_ANA   = 8'h94;
  localparam logic [7:0] OFS_LOCK  = 8'hE4;
  localparam logic [7:0] OFS_LVIOL = 8'hE8;
  localparam logic [23:0] LOCK_KEY = 24'h414343;

  typedef enum logic [1:0] {
    EDGE_RISE = 2'd0,
    EDGE_FALL = 2'd1,
    EDGE_BOTH = 2'd2,
    EDGE_NONE = 2'd3
  } edge_sel_e;

  typedef struct packed {
    logic      fault_en;
    logic      fault_src;
    logic      invert;
    edge_sel_e edge_sel;
    logic      enable;
    logic [2:0] plus_sel;
    logic [2:0] minus_sel;
  } mode_t;
endpackage

// File: rtl/cmp_sync_edge.sv
module cmp_sync_edge
  import cmp_ctrl_pkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      clr_i,
  input  logic      cmp_i,
  input  logic      invert_i,
  input  logic      enable_i,
  input  edge_sel_e edge_sel_i,
  output logic      level_o,
  output logic      edge_o
);
  localparam int LAST = STAGES - 1;

  logic [LAST:0] sync_q;
  logic          prev_q;
  logic          rise, fall;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else if (clr_i) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[LAST-1:0], cmp_i ^ invert_i};
      prev_q <= sync_q[LAST];
    end
  end

  assign level_o = sync_q[LAST];
  assign rise    = level_o & ~prev_q;
  assign fall    = ~level_o & prev_q;

  always_comb begin
    unique case (edge_sel_i)
      EDGE_RISE: edge_o = enable_i & rise;
      EDGE_FALL: edge_o = enable_i & fall;
      EDGE_BOTH: edge_o = enable_i & (rise | fall);
      default:   edge_o = 1'b0;
    endcase
  end

  // R3
  edge_moves_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    edge_o |-> (level_o != $past(level_o)));
endmodule

// File: rtl/cmp_wprot.sv
module cmp_wprot
  import cmp_ctrl_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        clr_i,
  input  logic        key_wr_i,
  input  logic [23:0] key_i,
  input  logic        key_en_i,
  input  logic        guarded_wr_i,
  input  logic        viol_rd_i,
  output logic        locked_o,
  output logic        viol_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      locked_o <= 1'b0;
      viol_o   <= 1'b0;
    end else if (clr_i) begin
      locked_o <= 1'b0;
      viol_o   <= 1'b0;
    end else begin
      if (key_wr_i && key_i == LOCK_KEY) locked_o <= key_en_i;
      if (guarded_wr_i && locked_o) viol_o <= 1'b1;
      else if (viol_rd_i)           viol_o <= 1'b0;
    end
  end

  // R9
  bad_key_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (key_wr_i && key_i != LOCK_KEY && !clr_i) |=> $stable(locked_o));
  // R10
  viol_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (locked_o && guarded_wr_i && !clr_i) |=> viol_o);
endmodule

// File: rtl/cmp_edge_ctrl.sv
module cmp_edge_ctrl
  import cmp_ctrl_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmp_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic [2:0]        minus_sel_o,
  output logic [2:0]        plus_sel_o,
  output logic              cmp_en_o,
  output logic              cur_sel_o,
  output logic [1:0]        hyst_o,
  output logic              fault_o,
  output logic              irq_o
);
  localparam int OFS_W = 8;

  logic [OFS_W-1:0] ofs;
  mode_t mode_q;
  logic  cur_sel_q;
  logic [1:0] hyst_q;
  logic  mask_q, flag_q;
  logic  level, edge_hit;
  logic  locked, viol;
  logic  swrst, mode_wr, ana_wr, stat_rd;
  logic  unused_bits;

  assign ofs         = OFS_W'(addr_i);
  assign swrst       = wr_en_i && ofs == OFS_CTRL && wdata_i[0];
  assign mode_wr     = wr_en_i && ofs == OFS_MODE;
  assign ana_wr      = wr_en_i && ofs == OFS_ANA;
  assign stat_rd     = rd_en_i && ofs == OFS_STAT;
  assign unused_bits = ^{wdata_i[11], wdata_i[7], wdata_i[3]};

  cmp_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (swrst),
    .cmp_i      (cmp_i),
    .invert_i   (mode_q.invert),
    .enable_i   (mode_q.enable),
    .edge_sel_i (mode_q.edge_sel),
    .level_o    (level),
    .edge_o     (edge_hit)
  );

  cmp_wprot u_wprot (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .clr_i        (swrst),
    .key_wr_i     (wr_en_i && ofs == OFS_LOCK),
    .key_i        (wdata_i[31:8]),
    .key_en_i     (wdata_i[0]),
    .guarded_wr_i (mode_wr || ana_wr),
    .viol_rd_i    (rd_en_i && ofs == OFS_LVIOL),
    .locked_o     (locked),
    .viol_o       (viol)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q    <= '0;
      cur_sel_q <= 1'b0;
      hyst_q    <= '0;
      mask_q    <= 1'b0;
      flag_q    <= 1'b0;
    end else if (swrst) begin
      mode_q    <= '0;
      cur_sel_q <= 1'b0;
      hyst_q    <= '0;
      mask_q    <= 1'b0;
      flag_q    <= 1'b0;
    end else begin
      if (mode_wr && !locked) begin
        mode_q.fault_en  <= wdata_i[14];
        mode_q.fault_src <= wdata_i[13];
        mode_q.invert    <= wdata_i[12];
        mode_q.edge_sel  <= edge_sel_e'(wdata_i[10:9]);
        mode_q.enable    <= wdata_i[8];
        mode_q.plus_sel  <= wdata_i[6:4];
        mode_q.minus_sel <= wdata_i[2:0];
      end
      if (ana_wr && !locked) begin
        cur_sel_q <= wdata_i[0];
        hyst_q    <= wdata_i[2:1];
      end
      if (wr_en_i && ofs == OFS_IEN && wdata_i[0])       mask_q <= 1'b1;
      else if (wr_en_i && ofs == OFS_IDIS && wdata_i[0]) mask_q <= 1'b0;
      // a new edge wins over the clear-on-read
      if (edge_hit)     flag_q <= 1'b1;
      else if (stat_rd) flag_q <= 1'b0;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (rd_en_i) begin
      unique case (ofs)
        OFS_MODE:  rdata_o = {17'b0, mode_q.fault_en, mode_q.fault_src, mode_q.invert,
                              1'b0, mode_q.edge_sel, mode_q.enable, 1'b0,
                              mode_q.plus_sel, 1'b0, mode_q.minus_sel};
        OFS_IMSK:  rdata_o = {31'b0, mask_q};
        OFS_STAT:  rdata_o = {30'b0, level, flag_q};
        OFS_ANA:   rdata_o = {29'b0, hyst_q, cur_sel_q};
        OFS_LOCK:  rdata_o = {31'b0, locked};
        OFS_LVIOL: rdata_o = {31'b0, viol};
        default:   rdata_o = '0;
      endcase
    end
  end

  assign minus_sel_o = mode_q.minus_sel;
  assign plus_sel_o  = mode_q.plus_sel;
  assign cmp_en_o    = mode_q.enable;
  assign cur_sel_o   = cur_sel_q;
  assign hyst_o      = hyst_q;
  assign fault_o     = mode_q.fault_en & (mode_q.fault_src ? level : flag_q);
  assign irq_o       = flag_q & mask_q;

  // R3
  flag_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag_q) |-> $past(edge_hit));
  // R5
  keep_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (edge_hit && stat_rd && !swrst) |=> flag_q);
  // R5
  read_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_rd && !edge_hit && !swrst) |=> !flag_q);
  // R10
  lock_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (locked && !swrst) |=> $stable(mode_q) && $stable(hyst_q) && $stable(cur_sel_q));
  // R11
  swrst_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    swrst |=> (mode_q == '0 && !mask_q && !flag_q && !locked && !viol));
endmodule

// File: tb/cmp_edge_ctrl_tb.sv
module cmp_edge_ctrl_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cmp_i = 1'b0;
  logic        wr_en_i = 1'b0;
  logic        rd_en_i = 1'b0;
  logic [7:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic [2:0]  minus_sel_o, plus_sel_o;
  logic        cmp_en_o, cur_sel_o, fault_o, irq_o;
  logic [1:0]  hyst_o;

  int vectors = 0;
  int miscompares = 0;

  typedef struct {
    int          req;
    logic [31:0] exp;
  } item_t;
  item_t sb_q[$];
  event  rd_ev;

  always #5 clk_i = ~clk_i;

  cmp_edge_ctrl u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .cmp_i(cmp_i),
    .wr_en_i(wr_en_i), .rd_en_i(rd_en_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o),
    .minus_sel_o(minus_sel_o), .plus_sel_o(plus_sel_o), .cmp_en_o(cmp_en_o),
    .cur_sel_o(cur_sel_o), .hyst_o(hyst_o), .fault_o(fault_o), .irq_o(irq_o)
  );

  // monitor: compares read data against the scoreboard
  initial begin
    forever begin
      item_t it;
      @(rd_ev);
      it = sb_q.pop_front();
      vectors++;
      if (rdata_o !== it.exp) begin
        miscompares++;
        $display("FAIL R%0d read addr %h: got %h expected %h", it.req, addr_i, rdata_o, it.exp);
      end
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0; wdata_i = '0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] e, input int req);
    @(negedge clk_i);
    rd_en_i = 1'b1; addr_i = a;
    sb_q.push_back('{req, e});
    #1;
    ->rd_ev;
    @(negedge clk_i);
    rd_en_i = 1'b0;
  endtask

  task automatic chk(input int req, input logic [31:0] act, input logic [31:0] e, input string what);
    vectors++;
    if (act !== e) begin
      miscompares++;
      $display("FAIL R%0d %s: got %h expected %h", req, what, act, e);
    end
  endtask

  task automatic drive(input logic v);
    @(negedge clk_i);
    cmp_i = v;
    repeat (4) @(negedge clk_i);
  endtask

  task automatic settle();
    repeat (4) @(negedge clk_i);
  endtask

  initial begin
    #2_000_000;
    miscompares++;
    $display("FAIL watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    // R11 reset state
    rd(8'h04, 32'h0, 11);
    rd(8'h30, 32'h0, 11);
    rd(8'h2C, 32'h0, 11);
    #1 chk(11, fault_o, 0, "fault after reset");
    chk(11, irq_o, 0, "irq after reset");

    // R1 field placement
    wr(8'h04, 32'h0000_0135);
    rd(8'h04, 32'h135, 1);
    #1 chk(1, minus_sel_o, 5, "minus select");
    chk(1, plus_sel_o, 3, "plus select");
    chk(1, cmp_en_o, 1, "enable");

    // R2 R3 rising only
    drive(1); rd(8'h30, 32'h3, 3); rd(8'h30, 32'h2, 2);
    drive(0); rd(8'h30, 32'h0, 3);
    // R3 falling only
    wr(8'h04, 32'h335);
    drive(1); rd(8'h30, 32'h2, 3);
    drive(0); rd(8'h30, 32'h1, 3); rd(8'h30, 32'h0, 5);
    // R3 any edge
    wr(8'h04, 32'h535);
    drive(1); rd(8'h30, 32'h3, 3);
    drive(0); rd(8'h30, 32'h1, 3);
    // R3 reserved edge kind
    wr(8'h04, 32'h735);
    drive(1); rd(8'h30, 32'h2, 3);
    drive(0); rd(8'h30, 32'h0, 3);
    // R4 inversion, rising kind
    wr(8'h04, 32'h1135);
    settle(); rd(8'h30, 32'h3, 4); rd(8'h30, 32'h2, 4);
    drive(1); rd(8'h30, 32'h0, 4);
    drive(0); rd(8'h30, 32'h3, 4); rd(8'h30, 32'h2, 4);
    // R3 disabled, any edge
    wr(8'h04, 32'h435);
    settle(); rd(8'h30, 32'h0, 3);
    drive(1); rd(8'h30, 32'h2, 3);
    drive(0); rd(8'h30, 32'h0, 3);

    // R6 interrupt mask
    wr(8'h04, 32'h535);
    wr(8'h24, 32'h1);
    rd(8'h2C, 32'h1, 6);
    #1 chk(6, irq_o, 0, "irq without flag");
    drive(1);
    #1 chk(6, irq_o, 1, "irq with flag and mask");
    rd(8'h30, 32'h3, 5);
    #1 chk(6, irq_o, 0, "irq after status read");
    wr(8'h28, 32'h1);
    rd(8'h2C, 32'h0, 6);
    drive(0);
    #1 chk(6, irq_o, 0, "irq masked");
    rd(8'h30, 32'h1, 5);

    // R7 fault sources
    wr(8'h04, 32'h4535);
    #1 chk(7, fault_o, 0, "fault flag source idle");
    drive(1);
    #1 chk(7, fault_o, 1, "fault from flag");
    rd(8'h30, 32'h3, 5);
    #1 chk(7, fault_o, 0, "fault after flag clear");
    wr(8'h04, 32'h6535);
    #1 chk(7, fault_o, 1, "fault from level high");
    drive(0);
    #1 chk(7, fault_o, 0, "fault from level low");
    drive(1);
    #1 chk(7, fault_o, 1, "fault from level high again");
    wr(8'h04, 32'h2535);
    #1 chk(7, fault_o, 0, "fault disabled");
    rd(8'h30, 32'h3, 5);

    // R5 edge in the same cycle as a status read
    wr(8'h04, 32'h535);
    drive(0);
    @(negedge clk_i); cmp_i = 1'b1;
    @(negedge clk_i);
    rd(8'h30, 32'h3, 5);
    settle();
    rd(8'h30, 32'h3, 5);
    rd(8'h30, 32'h2, 5);

    // R8 analog register
    wr(8'h94, 32'h5);
    rd(8'h94, 32'h5, 8);
    #1 chk(8, cur_sel_o, 1, "current select");
    chk(8, hyst_o, 2, "hysteresis");

    // R9 key handling
    wr(8'hE4, 32'h1234_5601);
    rd(8'hE4, 32'h0, 9);
    wr(8'hE4, 32'h4143_4301);
    rd(8'hE4, 32'h1, 9);
    // R10 locked writes
    wr(8'h04, 32'h0);
    rd(8'h04, 32'h535, 10);
    rd(8'hE8, 32'h1, 10);
    rd(8'hE8, 32'h0, 10);
    wr(8'h94, 32'h0);
    rd(8'h94, 32'h5, 10);
    #1 chk(10, hyst_o, 2, "hysteresis while locked");
    wr(8'hE4, 32'h4143_4300);
    rd(8'hE4, 32'h0, 9);
    wr(8'h04, 32'h135);
    rd(8'h04, 32'h135, 9);

    // R11 software reset
    wr(8'h24, 32'h1);
    drive(0); drive(1);
    #1 chk(6, irq_o, 1, "irq before soft reset");
    wr(8'hE4, 32'h4143_4301);
    wr(8'h00, 32'h1);
    #1 chk(11, irq_o, 0, "irq after soft reset");
    chk(11, fault_o, 0, "fault after soft reset");
    rd(8'h04, 32'h0, 11);
    rd(8'h2C, 32'h0, 11);
    rd(8'h94, 32'h0, 11);
    rd(8'hE4, 32'h0, 11);
    rd(8'h30, 32'h2, 11);

    repeat (2) @(negedge clk_i);
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule